// File: doc/BRIEF.md
# UART Command and Status Controller

This block is the register-side control logic of a simple UART. A host reaches it through a byte-wide memory-mapped read/write port. Through that port the host programs two mode registers that share one address, and issues packed commands. It also reads an 8-bit status register and an interrupt status register, writes an interrupt mask, loads a one-byte transmit holding buffer and reads received bytes. Baud generation, serial framing and receive FIFO storage sit outside the block. The block drives the transmit serializer through a valid/ready handshake. It takes level and pulse indications from the receive side, and it gives the receive FIFO a pop strobe and a flush strobe.

The command byte carries three independent fields. Two of them enable or disable the transmitter and the receiver. The third selects one of several one-shot actions: pointer rewind, receiver reset, transmitter reset, error clear, break-interrupt clear, and break start and stop. A single interrupt line is raised while any unmasked interrupt status bit is set. The receive interrupt source is chosen by a mode bit. It is either "at least one byte waiting" or "FIFO full".

Top module: `uart_ctrl_regs`

## Requirements
- R1: After reset the status register reads 0x08, with only the transmitter-empty bit (bit 3) set. The interrupt status reads 0x00, `irq` is low, `tx_valid` is low, and the mode pointer addresses mode register 1.
- R2: At offset 0x00, the first read or write reaches mode register 1 and moves the pointer to mode register 2, where it stays. Command byte 0x10 (action field bits 7:4 = 1) returns the pointer to mode register 1.
- R3: Command bits 3:2 control the transmitter and bits 1:0 control the receiver. Code 1 enables, code 2 disables, and codes 0 and 3 leave the state unchanged. Status bit 2 (TxRDY) equals the transmitter enable. `rx_en` equals the receiver enable.
- R4: A write to offset 0x0C stores the byte and clears status bit 3. While the transmitter is enabled and bit 3 is clear, `tx_valid` is high with the stored byte on `tx_data`. A cycle with `tx_valid` and `tx_ready` both high sets bit 3 again. While the transmitter is disabled, `tx_valid` stays low.
- R5: Action code 3 sets status bit 3, clears the transmitter enable and bit 2, and drops any pending byte.
- R6: Action code 2 clears the receiver enable and clears status bits 0 and 1 at that edge, whatever the receive inputs are. It also pulses `rx_flush` high for one cycle.
- R7: Status bit 0 follows `rx_nonempty` and bit 1 follows `rx_full`, one edge later. Bits 4, 5, 6 and 7 are sticky flags set by `rx_overrun`, `rx_parity`, `rx_framing` and `rx_break`. Action code 4 clears all four.
- R8: The interrupt status (read at offset 0x14) is built as follows. Bit 0 equals TxRDY. Bit 1 equals status bit 1 when mode register 1 bit 6 is set, and status bit 0 otherwise. Bit 2 is set by `rx_break` and cleared by action code 5. Bit 7 follows `cos_flag` one edge later. All other bits read 0.
- R9: A write to offset 0x14 loads the interrupt mask. `irq` is registered: it is high one edge after the bitwise AND of interrupt status and mask becomes nonzero, and low one edge after it becomes zero.
- R10: Action code 6 drives `tx_break` high and action code 7 drives it low.
- R11: Only address bits 5:0 are decoded. Offset 0x04 reads status, 0x08 takes commands, 0x0C is the buffer and 0x14 is interrupt status/mask. An access at 0x48 acts exactly as one at 0x08.
- R12: A read at offset 0x0C returns `rx_data` on `bus_rdata` and holds `rx_pop` high during that read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, decoded modulo 0x40 |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid during a read cycle |
| tx_valid | output | 1 | Holding byte offered to the serializer |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_data | output | DATA_W | Holding byte |
| tx_break | output | 1 | Force the line to break |
| rx_en | output | 1 | Receiver enable |
| rx_flush | output | 1 | One-cycle receive FIFO flush |
| rx_pop | output | 1 | Receive FIFO pop, high during a buffer read |
| rx_data | input | DATA_W | Head of the receive FIFO |
| rx_nonempty | input | 1 | Receive FIFO holds at least one byte |
| rx_full | input | 1 | Receive FIFO is full |
| rx_overrun | input | 1 | Overrun event pulse |
| rx_parity | input | 1 | Parity error event pulse |
| rx_framing | input | 1 | Framing error event pulse |
| rx_break | input | 1 | Received break event pulse |
| cos_flag | input | 1 | Change-of-state indication |
| irq | output | 1 | Interrupt request |

## Verification
Every register write takes effect at the rising edge that samples it. Status, the interrupt status, `tx_valid`, `tx_break`, `rx_en` and `rx_flush` are therefore checked at the falling edge right after the write cycle. `irq` is checked once at that same falling edge, where it must still show the old value, and again one cycle later. Read data and `rx_pop` are combinational, so they are checked during the read cycle itself. Receive-side inputs are applied one cycle before the status read that must show them. The bench posts each expected value to a scoreboard queue at the cycle it is due. A monitor compares it 2 ns after the falling edge.

// File: rtl/uart_ctrl_pkg.sv
package uart_ctrl_pkg;

   // register offsets inside the 64-byte window
   localparam int unsigned OFFS_W = 6;
   localparam logic [OFFS_W-1:0] OFF_MODE = 6'h00;
   localparam logic [OFFS_W-1:0] OFF_STAT = 6'h04;
   localparam logic [OFFS_W-1:0] OFF_CMD  = 6'h08;
   localparam logic [OFFS_W-1:0] OFF_BUF  = 6'h0C;
   localparam logic [OFFS_W-1:0] OFF_INT  = 6'h14;

   // status bit positions
   localparam int unsigned SB_RXRDY = 0;
   localparam int unsigned SB_FFULL = 1;
   localparam int unsigned SB_TXRDY = 2;
   localparam int unsigned SB_TXEMP = 3;
   localparam int unsigned SB_OVR   = 4;
   localparam int unsigned SB_PAR   = 5;
   localparam int unsigned SB_FRM   = 6;
   localparam int unsigned SB_BRK   = 7;

   // interrupt status bit positions
   localparam int unsigned IB_TX  = 0;
   localparam int unsigned IB_RX  = 1;
   localparam int unsigned IB_DB  = 2;
   localparam int unsigned IB_COS = 7;

   // mode register 1 bit choosing the receive interrupt source
   localparam int unsigned MODE_RXSRC_BIT = 6;

   typedef enum logic [1:0] {
      FLD_KEEP = 2'd0,
      FLD_ON   = 2'd1,
      FLD_OFF  = 2'd2,
      FLD_RSV  = 2'd3
   } fld_e;

   typedef enum logic [3:0] {
      ACT_NONE   = 4'd0,
      ACT_PTR    = 4'd1,
      ACT_RXRST  = 4'd2,
      ACT_TXRST  = 4'd3,
      ACT_ERRCLR = 4'd4,
      ACT_DBCLR  = 4'd5,
      ACT_BRKON  = 4'd6,
      ACT_BRKOFF = 4'd7
   } act_e;

   typedef struct packed {
      logic tx_on;
      logic tx_off;
      logic rx_on;
      logic rx_off;
      logic ptr_rst;
      logic rx_rst;
      logic tx_rst;
      logic err_clr;
      logic db_clr;
      logic brk_on;
      logic brk_off;
   } cmd_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
   import uart_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] cmd_byte,
   output cmd_t              cmd
);

   localparam int unsigned TXF_LO = 2;
   localparam int unsigned RXF_LO = 0;
   localparam int unsigned ACT_LO = 4;

   fld_e tx_f;
   fld_e rx_f;
   act_e act;

   assign tx_f = fld_e'(cmd_byte[TXF_LO +: 2]);
   assign rx_f = fld_e'(cmd_byte[RXF_LO +: 2]);
   assign act  = act_e'(cmd_byte[ACT_LO +: 4]);

   generate
      if (DATA_W > 8) begin : g_hi
         logic hi_bits_unused;
         assign hi_bits_unused = ^cmd_byte[DATA_W-1:8];
      end
   endgenerate

   always_comb begin
      cmd = '0;
      if (cmd_wr) begin
         cmd.tx_on  = (tx_f == FLD_ON);
         cmd.tx_off = (tx_f == FLD_OFF);
         cmd.rx_on  = (rx_f == FLD_ON);
         cmd.rx_off = (rx_f == FLD_OFF);
         case (act)
            ACT_PTR:    cmd.ptr_rst = 1'b1;
            ACT_RXRST:  cmd.rx_rst  = 1'b1;
            ACT_TXRST:  cmd.tx_rst  = 1'b1;
            ACT_ERRCLR: cmd.err_clr = 1'b1;
            ACT_DBCLR:  cmd.db_clr  = 1'b1;
            ACT_BRKON:  cmd.brk_on  = 1'b1;
            ACT_BRKOFF: cmd.brk_off = 1'b1;
            default:    ;
         endcase
      end
   end

endmodule

// File: rtl/uart_mode_regs.sv
module uart_mode_regs
   import uart_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ptr_rst,
   output logic [DATA_W-1:0] rd_val,
   output logic              rx_src_full
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_mode_regs: DEPTH must be at least 2");
      end
      if (DATA_W <= MODE_RXSRC_BIT) begin : g_bad_width
         $error("uart_mode_regs: DATA_W too small for the source select bit");
      end
   endgenerate

   logic [DATA_W-1:0] mr_q [DEPTH];
   logic [PTR_W-1:0]  ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (ptr_rst) begin
         ptr_q <= '0;
      end else if (acc && ptr_q != PTR_LAST) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mr_q[i] <= '0;
      end else if (acc && wr) begin
         mr_q[ptr_q] <= wdata;
      end
   end

   assign rd_val      = mr_q[ptr_q];
   assign rx_src_full = mr_q[0][MODE_RXSRC_BIT];

   AST_PTR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ptr_rst) |=> (ptr_q != '0)); // R2
   AST_PTR_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_rst |=> (ptr_q == '0)); // R2

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
   import uart_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_t              cmd,
   input  logic              tb_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_en,
   output logic              tx_empty,
   output logic              tx_break
);

   logic              en_q;
   logic              empty_q;
   logic              brk_q;
   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (cmd.tx_on) begin
         en_q <= 1'b1;
      end else if (cmd.tx_off || cmd.tx_rst) begin
         en_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
      end else if (tb_wr) begin
         empty_q <= 1'b0;
      end else if (cmd.tx_rst || (tx_valid && tx_ready)) begin
         empty_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (tb_wr) begin
         hold_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_q <= 1'b0;
      end else if (cmd.brk_on) begin
         brk_q <= 1'b1;
      end else if (cmd.brk_off) begin
         brk_q <= 1'b0;
      end
   end

   assign tx_valid = en_q && !empty_q;
   assign tx_data  = hold_q;
   assign tx_en    = en_q;
   assign tx_empty = empty_q;
   assign tx_break = brk_q;

   AST_TX_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && !tb_wr) |=> tx_empty); // R4
   AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      tb_wr |=> (!tx_empty && tx_data == $past(wdata))); // R4
   AST_TX_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.tx_rst && !cmd.tx_on) |=> (tx_empty && !tx_en && !tx_valid)); // R5
   AST_BRK_START: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.brk_on |=> tx_break); // R10
   AST_BRK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.brk_off |=> !tx_break); // R10

endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
   import uart_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_t              cmd,
   input  logic              tx_en,
   input  logic              tx_empty,
   input  logic              rx_src_full,
   input  logic              rx_nonempty,
   input  logic              rx_full,
   input  logic              rx_overrun,
   input  logic              rx_parity,
   input  logic              rx_framing,
   input  logic              rx_break,
   input  logic              cos_flag,
   input  logic              imr_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] status,
   output logic [DATA_W-1:0] isr,
   output logic              irq,
   output logic              rx_en,
   output logic              rx_flush
);

   localparam int unsigned ERR_N = 4;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("uart_stat_irq: DATA_W must be at least 8");
      end
   endgenerate

   logic             rxen_q;
   logic             rxrdy_q;
   logic             ffull_q;
   logic [ERR_N-1:0] err_q;
   logic [ERR_N-1:0] err_in;
   logic             db_q;
   logic             cos_q;
   logic             flush_q;
   logic [DATA_W-1:0] imr_q;

   assign err_in = {rx_break, rx_framing, rx_parity, rx_overrun};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxen_q <= 1'b0;
      end else if (cmd.rx_on) begin
         rxen_q <= 1'b1;
      end else if (cmd.rx_off || cmd.rx_rst) begin
         rxen_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxrdy_q <= 1'b0;
         ffull_q <= 1'b0;
      end else if (cmd.rx_rst) begin
         rxrdy_q <= 1'b0;
         ffull_q <= 1'b0;
      end else begin
         rxrdy_q <= rx_nonempty;
         ffull_q <= rx_full;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q   <= '0;
         db_q    <= 1'b0;
         cos_q   <= 1'b0;
         flush_q <= 1'b0;
      end else begin
         err_q   <= (cmd.err_clr ? '0 : err_q) | err_in;
         db_q    <= (db_q && !cmd.db_clr) || rx_break;
         cos_q   <= cos_flag;
         flush_q <= cmd.rx_rst;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imr_q <= '0;
      end else if (imr_wr) begin
         imr_q <= wdata;
      end
   end

   always_comb begin
      status = '0;
      status[SB_RXRDY] = rxrdy_q;
      status[SB_FFULL] = ffull_q;
      status[SB_TXRDY] = tx_en;
      status[SB_TXEMP] = tx_empty;
      status[SB_OVR]   = err_q[0];
      status[SB_PAR]   = err_q[1];
      status[SB_FRM]   = err_q[2];
      status[SB_BRK]   = err_q[3];
   end

   always_comb begin
      isr = '0;
      isr[IB_TX]  = tx_en;
      isr[IB_RX]  = rx_src_full ? ffull_q : rxrdy_q;
      isr[IB_DB]  = db_q;
      isr[IB_COS] = cos_q;
   end

   assign rx_en    = rxen_q;
   assign rx_flush = flush_q;

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |(isr & imr_q);
         end
         assign irq = irq_q;

         AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
            (|(isr & imr_q)) |=> irq); // R9
         AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
            !(|(isr & imr_q)) |=> !irq); // R9
      end else begin : g_irq_comb
         assign irq = |(isr & imr_q);
      end
   endgenerate

   AST_RX_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.rx_rst |=> (!status[SB_RXRDY] && !status[SB_FFULL] && rx_flush)); // R6
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.err_clr && !(|err_in)) |=> (status[SB_BRK:SB_OVR] == '0)); // R7
   AST_DB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.db_clr && !rx_break) |=> !isr[IB_DB]); // R8

endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
   import uart_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned MODE_DEPTH = 2,
   parameter bit          IRQ_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_break,
   output logic              rx_en,
   output logic              rx_flush,
   output logic              rx_pop,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_nonempty,
   input  logic              rx_full,
   input  logic              rx_overrun,
   input  logic              rx_parity,
   input  logic              rx_framing,
   input  logic              rx_break,
   input  logic              cos_flag,
   output logic              irq
);

   generate
      if (ADDR_W < OFFS_W) begin : g_bad_addr
         $error("uart_ctrl_regs: ADDR_W must cover the register window");
      end
      if (ADDR_W > OFFS_W) begin : g_hi_addr
         logic addr_hi_unused;
         assign addr_hi_unused = ^bus_addr[ADDR_W-1:OFFS_W];
      end
   endgenerate

   logic [OFFS_W-1:0] off;
   logic hit_mode, hit_stat, hit_cmd, hit_buf, hit_int;
   logic rd_cyc, wr_cyc;

   assign off      = bus_addr[OFFS_W-1:0];
   assign rd_cyc   = bus_sel && !bus_wr;
   assign wr_cyc   = bus_sel && bus_wr;
   assign hit_mode = bus_sel && (off == OFF_MODE);
   assign hit_stat = bus_sel && (off == OFF_STAT);
   assign hit_cmd  = bus_sel && (off == OFF_CMD);
   assign hit_buf  = bus_sel && (off == OFF_BUF);
   assign hit_int  = bus_sel && (off == OFF_INT);

   cmd_t              cmd;
   logic [DATA_W-1:0] mode_val;
   logic              rx_src_full;
   logic              tx_en;
   logic              tx_empty;
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] isr;

   uart_cmd_decode #(.DATA_W(DATA_W)) u_dec (
      .cmd_wr   (hit_cmd && bus_wr),
      .cmd_byte (bus_wdata),
      .cmd      (cmd)
   );

   uart_mode_regs #(.DATA_W(DATA_W), .DEPTH(MODE_DEPTH)) u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc         (hit_mode),
      .wr          (bus_wr),
      .wdata       (bus_wdata),
      .ptr_rst     (cmd.ptr_rst),
      .rd_val      (mode_val),
      .rx_src_full (rx_src_full)
   );

   uart_tx_hold #(.DATA_W(DATA_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .tb_wr    (hit_buf && bus_wr),
      .wdata    (bus_wdata),
      .tx_ready (tx_ready),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .tx_en    (tx_en),
      .tx_empty (tx_empty),
      .tx_break (tx_break)
   );

   uart_stat_irq #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd         (cmd),
      .tx_en       (tx_en),
      .tx_empty    (tx_empty),
      .rx_src_full (rx_src_full),
      .rx_nonempty (rx_nonempty),
      .rx_full     (rx_full),
      .rx_overrun  (rx_overrun),
      .rx_parity   (rx_parity),
      .rx_framing  (rx_framing),
      .rx_break    (rx_break),
      .cos_flag    (cos_flag),
      .imr_wr      (hit_int && bus_wr),
      .wdata       (bus_wdata),
      .status      (status),
      .isr         (isr),
      .irq         (irq),
      .rx_en       (rx_en),
      .rx_flush    (rx_flush)
   );

   assign rx_pop = hit_buf && rd_cyc;

   always_comb begin
      bus_rdata = '0;
      if (rd_cyc) begin
         case (off)
            OFF_MODE: bus_rdata = mode_val;
            OFF_STAT: bus_rdata = status;
            OFF_BUF:  bus_rdata = rx_data;
            OFF_INT:  bus_rdata = isr;
            default:  bus_rdata = '0;
         endcase
      end
   end

   AST_CMD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cyc |-> (cmd == '0)); // R11
   AST_POP_ONEHOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_mode, hit_stat, hit_cmd, hit_buf, hit_int})); // R11

endmodule

// File: tb/uart_ctrl_regs_tb.sv
module uart_ctrl_regs_tb;

   localparam int AW = 8;
   localparam int DW = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic          bus_sel, bus_wr;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;
   logic          tx_valid, tx_ready, tx_break;
   logic [DW-1:0] tx_data;
   logic          rx_en, rx_flush, rx_pop;
   logic [DW-1:0] rx_data;
   logic          rx_nonempty, rx_full, rx_overrun, rx_parity, rx_framing, rx_break;
   logic          cos_flag, irq;

   uart_ctrl_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_break(tx_break), .rx_en(rx_en), .rx_flush(rx_flush), .rx_pop(rx_pop),
      .rx_data(rx_data), .rx_nonempty(rx_nonempty), .rx_full(rx_full),
      .rx_overrun(rx_overrun), .rx_parity(rx_parity), .rx_framing(rx_framing),
      .rx_break(rx_break), .cos_flag(cos_flag), .irq(irq)
   );

   typedef enum int {OB_RDATA, OB_IRQ, OB_TXV, OB_TXD, OB_BRK, OB_RXEN, OB_FLUSH, OB_POP} obs_e;
   typedef struct {
      string       req;
      obs_e        kind;
      logic [7:0]  exp;
   } item_t;

   item_t sb_q[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;

   function automatic logic [7:0] sample(obs_e k);
      case (k)
         OB_RDATA: return bus_rdata;
         OB_IRQ:   return {7'd0, irq};
         OB_TXV:   return {7'd0, tx_valid};
         OB_TXD:   return tx_data;
         OB_BRK:   return {7'd0, tx_break};
         OB_RXEN:  return {7'd0, rx_en};
         OB_FLUSH: return {7'd0, rx_flush};
         default:  return {7'd0, rx_pop};
      endcase
   endfunction

   task automatic expect_now(string r, obs_e k, logic [7:0] e);
      item_t it;
      it.req = r; it.kind = k; it.exp = e;
      sb_q.push_back(it);
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [7:0] e, string r);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      expect_now(r, OB_RDATA, e);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   // monitor: compares every due expectation shortly after the falling edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sb_q.size() > 0) begin
            item_t      it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = sample(it.kind);
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h", it.req, it.kind, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      tx_ready = 1'b0; rx_data = '0; rx_nonempty = 1'b0; rx_full = 1'b0;
      rx_overrun = 1'b0; rx_parity = 1'b0; rx_framing = 1'b0; rx_break = 1'b0;
      cos_flag = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      expect_now("R1 irq", OB_IRQ, 8'h00);
      expect_now("R1 tx_valid", OB_TXV, 8'h00);
      rd(8'h04, 8'h08, "R1 status");
      rd(8'h14, 8'h00, "R1 isr");

      // R2: pointer walk over the two mode registers
      wr(8'h00, 8'h00);
      wr(8'h00, 8'h13);
      rd(8'h00, 8'h13, "R2 stays on mode2");
      rd(8'h00, 8'h13, "R2 still mode2");
      wr(8'h08, 8'h10);
      rd(8'h00, 8'h00, "R2 rewound to mode1");
      rd(8'h00, 8'h13, "R2 advanced again");

      // R11 + R3: command via aliased address, transmitter on
      wr(8'h48, 8'h04);
      rd(8'h44, 8'h0C, "R11 R3 alias status");
      rd(8'h14, 8'h01, "R8 isr tx bit");

      // R9: mask then registered interrupt
      wr(8'h14, 8'h01);
      expect_now("R9 irq not yet", OB_IRQ, 8'h00);
      tick();
      expect_now("R9 irq raised", OB_IRQ, 8'h01);

      // R4: holding buffer handshake
      wr(8'h0C, 8'hA5);
      expect_now("R4 tx_valid", OB_TXV, 8'h01);
      expect_now("R4 tx_data", OB_TXD, 8'hA5);
      rd(8'h04, 8'h04, "R4 status pending");
      tx_ready = 1'b1;
      tick();
      tx_ready = 1'b0;
      expect_now("R4 tx_valid done", OB_TXV, 8'h00);
      rd(8'h04, 8'h0C, "R4 status empty");

      // R3: disable transmitter, reserved codes
      wr(8'h08, 8'h08);
      rd(8'h04, 8'h08, "R3 tx disabled");
      expect_now("R9 irq falls", OB_IRQ, 8'h00);
      wr(8'h0C, 8'h3C);
      expect_now("R4 no valid while off", OB_TXV, 8'h00);
      rd(8'h04, 8'h00, "R4 status loaded");
      wr(8'h08, 8'h0C);
      rd(8'h04, 8'h00, "R3 reserved tx code");
      wr(8'h08, 8'h04);
      expect_now("R4 valid after enable", OB_TXV, 8'h01);
      expect_now("R4 data kept", OB_TXD, 8'h3C);

      // R5: transmitter reset
      wr(8'h08, 8'h30);
      expect_now("R5 tx_valid", OB_TXV, 8'h00);
      rd(8'h04, 8'h08, "R5 status");

      // R3: receiver field
      wr(8'h08, 8'h01);
      expect_now("R3 rx_en on", OB_RXEN, 8'h01);
      wr(8'h08, 8'h03);
      expect_now("R3 rx reserved", OB_RXEN, 8'h01);

      // R7 + R8: receive status and interrupt source
      rx_nonempty = 1'b1;
      tick();
      rd(8'h04, 8'h09, "R7 rxrdy");
      rd(8'h14, 8'h02, "R8 rx irq from rxrdy");
      rx_full = 1'b1;
      tick();
      rd(8'h04, 8'h0B, "R7 ffull");

      // R12: buffer read
      rx_data = 8'h5A;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h0C;
      expect_now("R12 rx data", OB_RDATA, 8'h5A);
      expect_now("R12 rx_pop", OB_POP, 8'h01);
      tick();
      bus_sel = 1'b0;
      expect_now("R12 pop ends", OB_POP, 8'h00);

      // R2 + R8: mode1 bit6 selects FIFO-full source
      wr(8'h08, 8'h10);
      wr(8'h00, 8'h40);
      rx_full = 1'b0;
      tick();
      rd(8'h14, 8'h00, "R8 full source clear");
      rx_full = 1'b1;
      tick();
      rd(8'h14, 8'h02, "R8 full source set");

      // R7: sticky error flags and clear
      rx_overrun = 1'b1; rx_parity = 1'b1; rx_framing = 1'b1; rx_break = 1'b1;
      tick();
      rx_overrun = 1'b0; rx_parity = 1'b0; rx_framing = 1'b0; rx_break = 1'b0;
      rd(8'h04, 8'hFB, "R7 errors set");
      rd(8'h14, 8'h06, "R8 delta break");
      wr(8'h08, 8'h40);
      rd(8'h04, 8'h0B, "R7 errors cleared");
      rd(8'h14, 8'h06, "R8 db survives err clear");
      wr(8'h08, 8'h50);
      rd(8'h14, 8'h02, "R8 db cleared");

      // R6: receiver reset
      wr(8'h08, 8'h20);
      expect_now("R6 flush pulse", OB_FLUSH, 8'h01);
      expect_now("R6 rx_en off", OB_RXEN, 8'h00);
      rd(8'h04, 8'h08, "R6 status cleared");
      expect_now("R6 flush ends", OB_FLUSH, 8'h00);
      rx_nonempty = 1'b0; rx_full = 1'b0; cos_flag = 1'b1;
      tick();

      // R8 + R9: change of state
      rd(8'h14, 8'h80, "R8 cos bit");
      wr(8'h14, 8'h80);
      expect_now("R9 irq lag", OB_IRQ, 8'h00);
      tick();
      expect_now("R9 irq cos", OB_IRQ, 8'h01);

      // R10: break control
      wr(8'h08, 8'h60);
      expect_now("R10 break on", OB_BRK, 8'h01);
      wr(8'h08, 8'h70);
      expect_now("R10 break off", OB_BRK, 8'h00);

      tick();
      tick();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule